// File: doc/BRIEF.md
# Gray-Order Chase Syndrome Updater

This block produces the syndromes of successive Chase test vectors over GF(2^8) without recomputing them from the frame. The vectors are visited in an order where each one differs from its predecessor in exactly one bit of one weak symbol. Because of that, each of the 16 syndromes only needs an increment. The increment is the flipped bit's weight, 2^pos, times the weak symbol's root α^j raised to the syndrome's evaluation power. The block keeps a bank of the 16 most recent syndromes. When a vector begins a new sequence, the bank is first loaded from the hard-decision syndromes.

A caller presents a weak-symbol selector, a "new sequence" flag and the per-symbol root and bit-position tables, then pulses a start strobe while the block is ready. The block takes one clock per syndrome and streams the updated syndromes out in index order, one per cycle. Each group carries markers for its final syndrome and for belonging to the first vector of a sequence. A new start may be accepted in the final cycle of a group, which gives gap-free streaming.

Top module: `syn_update_gray`

## Requirements
- R1: During reset and after it ends, syn_valid_o is low and ready_o is high until a start is accepted.
- R2: A start is accepted at a rising edge where start_i and ready_o are both high. The group's syndrome 0 is then visible after the second rising edge following acceptance, and indices 1..15 follow on consecutive cycles in ascending order, with syn_valid_o high throughout.
- R3: For a vector whose first_i was high at acceptance, output syndrome i (i = 0..15, carried in hd_syn_i bits [8i+7:8i]) equals hd[i] XOR (2^pos · root^(i+1)) over GF(2^8).
- R4: For a vector whose first_i was low, output syndrome i equals the previous group's syndrome i XOR (2^pos · root^(i+1)).
- R5: The root (root_i bits [8k+7:8k]) and pos (pos_i bits [3k+2:3k]) of the weak symbol k = sel_i are sampled only at acceptance. Later changes do not alter the running group.
- R6: A start strobe while ready_o is low is ignored: it produces no extra group and does not change any output value.
- R7: syn_last_o is high exactly on the output cycle carrying index 15.
- R8: syn_first_o equals the first_i value sampled at the group's acceptance, on all 16 cycles of the group.
- R9: A start accepted in a group's final cycle begins the next group with no idle cycle. That group builds on all 16 results of the finished group, including syndrome 15.
- R10: Field arithmetic uses the primitive polynomial x^8+x^4+x^3+x^2+1 (0x11D), addition is XOR, and every pos from 0 to 7 scales correctly through the reduction.
- R11: hd_syn_i is sampled only when a new-sequence vector is accepted. This includes a back-to-back acceptance, where the reload overrides the finishing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin the next test vector |
| first_i | input | 1 | Vector begins a new sequence (start from hard-decision syndromes) |
| sel_i | input | 2 | Index of the weak symbol that flips |
| root_i | input | 32 | Four 8-bit roots α^j of the weak symbols |
| pos_i | input | 12 | Four 3-bit positions of the flipped bit within each weak symbol |
| hd_syn_i | input | 128 | Sixteen 8-bit hard-decision syndromes |
| ready_o | output | 1 | A start would be accepted at the next edge |
| syn_valid_o | output | 1 | syn_o carries an updated syndrome |
| syn_idx_o | output | 4 | Index of the syndrome on syn_o |
| syn_o | output | 8 | Updated syndrome value |
| syn_first_o | output | 1 | Group belongs to the first vector of a sequence |
| syn_last_o | output | 1 | Final syndrome of the group |

## Verification
Two functions can fall in the same cycle. One is the update of syndrome 15 of a finishing vector. The other is the acceptance of the next vector, which reloads root, pos and counter, and for a new sequence also reloads the whole bank from the hard-decision syndromes. The bench provokes this by raising start as soon as ready_o rises inside a running group. It does so for back-to-back continuation vectors and for a continuation followed by a new-sequence vector whose hard-decision syndromes were changed beforehand. Each case is judged by checking that there is no gap cycle, that the follow-on group's syndrome 15 includes the finished group's syndrome 15, and that a new-sequence group reflects the fresh hard-decision values rather than the stale bank.

// File: rtl/sus_pkg.sv
package sus_pkg;
    localparam int SYM_W_DEF = 8;
    localparam logic [8:0] FIELD_POLY_DEF = 9'h11D;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/sus_gf_scale.sv
// Multiplies a field element by 2^pos through a chain of shift-and-reduce
// stages; the stage picked by pos is the result.
module sus_gf_scale #(
    parameter int         W     = 8,
    parameter int         POS_W = 3,
    parameter logic [W:0] POLY  = 9'h11D
) (
    input  logic [W-1:0]     a_i,
    input  logic [POS_W-1:0] pos_i,
    output logic [W-1:0]     y_o
);
    localparam int NSTG = 1 << POS_W;

    logic [W-1:0] stg [NSTG];

    assign stg[0] = a_i;

    generate
        for (genvar k = 1; k < NSTG; k++) begin : g_stage
            assign stg[k] = {stg[k-1][W-2:0], 1'b0}
                          ^ (stg[k-1][W-1] ? POLY[W-1:0] : '0);
        end
    endgenerate

    assign y_o = stg[pos_i];
endmodule

// File: rtl/sus_gf_mul.sv
// Full field multiply used to advance the running power of the root.
module sus_gf_mul #(
    parameter int         W    = 8,
    parameter logic [W:0] POLY = 9'h11D
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o
);
    logic [W-1:0] part [W];

    assign part[0] = a_i;

    generate
        for (genvar k = 1; k < W; k++) begin : g_part
            assign part[k] = {part[k-1][W-2:0], 1'b0}
                           ^ (part[k-1][W-1] ? POLY[W-1:0] : '0);
        end
    endgenerate

    always_comb begin
        p_o = '0;
        for (int k = 0; k < W; k++) begin
            if (b_i[k]) begin
                p_o = p_o ^ part[k];
            end
        end
    end
endmodule

// File: rtl/sus_seq.sv
// Step sequencer: accepts a start, then walks the syndrome index once.
module sus_seq #(
    parameter int NSYN  = 16,
    parameter int CNT_W = $clog2(NSYN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             ready_o,
    output logic             accept_o,
    output logic             step_o,
    output logic             final_o,
    output logic [CNT_W-1:0] cnt_o
);
    import sus_pkg::*;

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NSYN - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t q, d;

    assign step_o   = (q.state == SEQ_RUN);
    assign final_o  = step_o && (q.cnt == LAST_IDX);
    assign ready_o  = !step_o || final_o;
    assign accept_o = start_i && ready_o;
    assign cnt_o    = q.cnt;

    always_comb begin
        d = q;
        if (step_o) begin
            if (final_o) begin
                d.state = SEQ_IDLE;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (accept_o) begin
            d.state = SEQ_RUN;
            d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: SEQ_IDLE, cnt: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/syn_update_gray.sv
// Incremental syndrome updater for Gray-ordered Chase test vectors.
module syn_update_gray #(
    parameter int         W     = sus_pkg::SYM_W_DEF,
    parameter int         NSYN  = 16,
    parameter int         NWEAK = 4,
    parameter logic [W:0] POLY  = sus_pkg::FIELD_POLY_DEF,
    parameter int         POS_W = $clog2(W),
    parameter int         IDX_W = (NWEAK > 1) ? $clog2(NWEAK) : 1,
    parameter int         CNT_W = $clog2(NSYN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   first_i,
    input  logic [IDX_W-1:0]       sel_i,
    input  logic [NWEAK*W-1:0]     root_i,
    input  logic [NWEAK*POS_W-1:0] pos_i,
    input  logic [NSYN*W-1:0]      hd_syn_i,
    output logic                   ready_o,
    output logic                   syn_valid_o,
    output logic [CNT_W-1:0]       syn_idx_o,
    output logic [W-1:0]           syn_o,
    output logic                   syn_first_o,
    output logic                   syn_last_o
);
    typedef struct packed {
        logic [NSYN-1:0][W-1:0] bank;
        logic [W-1:0]           root;
        logic [W-1:0]           factor;
        logic [POS_W-1:0]       pos;
        logic                   first;
        logic                   o_valid;
        logic [CNT_W-1:0]       o_idx;
        logic [W-1:0]           o_syn;
        logic                   o_first;
        logic                   o_last;
    } upd_t;

    upd_t q, d;

    logic             accept, step, fin;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     root_sel;
    logic [POS_W-1:0] pos_sel;
    logic [W-1:0]     term;
    logic [W-1:0]     next_factor;
    logic [W-1:0]     new_syn;

    sus_seq #(
        .NSYN  (NSYN),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .ready_o  (ready_o),
        .accept_o (accept),
        .step_o   (step),
        .final_o  (fin),
        .cnt_o    (cnt)
    );

    // Weak-symbol table lookup
    always_comb begin
        root_sel = '0;
        pos_sel  = '0;
        for (int k = 0; k < NWEAK; k++) begin
            if (sel_i == IDX_W'(k)) begin
                root_sel = root_i[k*W +: W];
                pos_sel  = pos_i[k*POS_W +: POS_W];
            end
        end
    end

    // Increment: running root power scaled by the flipped bit's weight
    sus_gf_scale #(
        .W     (W),
        .POS_W (POS_W),
        .POLY  (POLY)
    ) u_scale (
        .a_i   (q.factor),
        .pos_i (q.pos),
        .y_o   (term)
    );

    // Advance the running power to the next evaluation point
    sus_gf_mul #(
        .W    (W),
        .POLY (POLY)
    ) u_mul (
        .a_i (q.factor),
        .b_i (q.root),
        .p_o (next_factor)
    );

    assign new_syn = q.bank[cnt] ^ term;

    always_comb begin
        d         = q;
        d.o_valid = 1'b0;
        d.o_last  = 1'b0;
        if (step) begin
            d.bank[cnt] = new_syn;
            d.factor    = next_factor;
            d.o_valid   = 1'b1;
            d.o_idx     = cnt;
            d.o_syn     = new_syn;
            d.o_first   = q.first;
            d.o_last    = fin;
        end
        // Acceptance comes last so a sequence reload wins over the final write
        if (accept) begin
            d.root   = root_sel;
            d.factor = root_sel;
            d.pos    = pos_sel;
            d.first  = first_i;
            if (first_i) begin
                d.bank = hd_syn_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign syn_valid_o = q.o_valid;
    assign syn_idx_o   = q.o_idx;
    assign syn_o       = q.o_syn;
    assign syn_first_o = q.o_first;
    assign syn_last_o  = q.o_last;
endmodule

// File: rtl/sus_checker.sv
module sus_checker #(
    parameter int NSYN  = 16,
    parameter int CNT_W = $clog2(NSYN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             ready_o,
    input logic             syn_valid_o,
    input logic [CNT_W-1:0] syn_idx_o,
    input logic             syn_first_o,
    input logic             syn_last_o
);
    // R1
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !syn_valid_o);

    // R2
    a_r2_group_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ready_o) ##1 1'b1 |=> syn_valid_o && (syn_idx_o == '0));

    // R2
    a_r2_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_valid_o && !syn_last_o) |=>
            syn_valid_o && (syn_idx_o == CNT_W'($past(syn_idx_o) + 1'b1)));

    // R7
    a_r7_last_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_valid_o && syn_last_o) |-> (syn_idx_o == CNT_W'(NSYN - 1)));

    // R8
    a_r8_first_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_valid_o && !syn_last_o) |=> (syn_first_o == $past(syn_first_o)));
endmodule

bind syn_update_gray sus_checker #(
    .NSYN (NSYN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ready_o     (ready_o),
    .syn_valid_o (syn_valid_o),
    .syn_idx_o   (syn_idx_o),
    .syn_first_o (syn_first_o),
    .syn_last_o  (syn_last_o)
);

// File: tb/syn_update_gray_bench.sv
module syn_update_gray_bench;
    localparam int W = 8, NSYN = 16, NWEAK = 4, POS_W = 3, IDX_W = 2, CNT_W = 4;
    localparam int MAXG = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic                   first_i = 1'b0;
    logic [IDX_W-1:0]       sel_i = '0;
    logic [NWEAK*W-1:0]     root_i = '0;
    logic [NWEAK*POS_W-1:0] pos_i = '0;
    logic [NSYN*W-1:0]      hd_syn_i = '0;
    logic                   ready_o, syn_valid_o, syn_first_o, syn_last_o;
    logic [CNT_W-1:0]       syn_idx_o;
    logic [W-1:0]           syn_o;

    always #2 clk = ~clk;

    syn_update_gray u_syn_update_gray (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .first_i (first_i),
        .sel_i (sel_i), .root_i (root_i), .pos_i (pos_i), .hd_syn_i (hd_syn_i),
        .ready_o (ready_o), .syn_valid_o (syn_valid_o), .syn_idx_o (syn_idx_o),
        .syn_o (syn_o), .syn_first_o (syn_first_o), .syn_last_o (syn_last_o)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Output capture
    logic [W-1:0] g_val  [MAXG*NSYN];
    logic [3:0]   g_idx  [MAXG*NSYN];
    logic         g_fst  [MAXG*NSYN];
    logic         g_lst  [MAXG*NSYN];
    int           g_cyc  [MAXG*NSYN];
    int           ngot = 0;

    always @(negedge clk) begin
        if (rst_n && syn_valid_o && ngot < MAXG*NSYN) begin
            g_val[ngot] = syn_o;
            g_idx[ngot] = syn_idx_o;
            g_fst[ngot] = syn_first_o;
            g_lst[ngot] = syn_last_o;
            g_cyc[ngot] = cyc;
            ngot = ngot + 1;
        end
    end

    // Reference model
    logic [W-1:0]     root_m [NWEAK];
    logic [POS_W-1:0] pos_m  [NWEAK];
    logic [W-1:0]     hd_m   [NSYN];
    logic [W-1:0]     cur    [NSYN];
    logic [W-1:0]     exp_v  [MAXG][NSYN];
    logic             exp_f  [MAXG];
    int               acc_c  [MAXG];
    int               ngrp = 0;

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) r = r ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] gpow(input logic [7:0] a, input int e);
        logic [7:0] r = 8'h01;
        for (int k = 0; k < e; k++) r = gmul(r, a);
        return r;
    endfunction

    task automatic drive_tables();
        for (int k = 0; k < NWEAK; k++) begin
            root_i[k*W +: W]        = root_m[k];
            pos_i[k*POS_W +: POS_W] = pos_m[k];
        end
        for (int i = 0; i < NSYN; i++) hd_syn_i[i*W +: W] = hd_m[i];
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
        end
    endtask

    // Called at a negedge; raises start once ready and updates the model
    task automatic issue(input int sel, input bit first);
        while (!ready_o) @(negedge clk);
        start_i = 1'b1;
        sel_i   = IDX_W'(sel);
        first_i = first;
        acc_c[ngrp] = cyc;
        exp_f[ngrp] = first;
        for (int i = 0; i < NSYN; i++) begin
            if (first) cur[i] = hd_m[i];
            cur[i] = cur[i] ^ gmul(8'(1 << pos_m[sel]), gpow(root_m[sel], i + 1));
            exp_v[ngrp][i] = cur[i];
        end
        ngrp++;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_groups(input int from, input int upto, input string req);
        int waitc = 0;
        while (ngot < upto*NSYN && waitc < 400) begin
            @(negedge clk);
            waitc++;
        end
        chk(ngot >= upto*NSYN, {req, " R2 group count"}, ngot, upto*NSYN);
        for (int g = from; g < upto; g++) begin
            for (int k = 0; k < NSYN; k++) begin
                int e = g*NSYN + k;
                if (e < ngot) begin
                    chk(g_val[e] == exp_v[g][k], req, int'(g_val[e]), int'(exp_v[g][k]));
                    chk(g_idx[e] == 4'(k), "R2 index order", int'(g_idx[e]), k);
                    chk(g_lst[e] == (k == NSYN-1), "R7 last marker", int'(g_lst[e]), int'(k == NSYN-1));
                    chk(g_fst[e] == exp_f[g], "R8 first marker", int'(g_fst[e]), int'(exp_f[g]));
                    chk(g_cyc[e] == acc_c[g] + 2 + k, "R2 R9 output timing", g_cyc[e], acc_c[g] + 2 + k);
                end
            end
        end
    endtask

    task automatic t_reset();
        chk(syn_valid_o == 1'b0, "R1 valid after reset", int'(syn_valid_o), 0);
        chk(ready_o == 1'b1, "R1 ready after reset", int'(ready_o), 1);
    endtask

    // R3, R10: pos 7 with reduction, fresh sequence
    task automatic t_first_vector();
        int g0 = ngrp;
        issue(1, 1'b1);
        check_groups(g0, ngrp, "R3 R10 first-vector syndrome");
    endtask

    // R4, R9: continuation vectors started back to back
    task automatic t_continuation();
        int g0 = ngrp;
        issue(0, 1'b0);
        issue(2, 1'b0);
        issue(0, 1'b0);
        issue(3, 1'b0);
        check_groups(g0, ngrp, "R4 R9 continuation syndrome");
    endtask

    // R5, R11: tables change right after acceptance
    task automatic t_hold_inputs();
        int g0 = ngrp;
        issue(2, 1'b1);
        for (int k = 0; k < NWEAK; k++) begin
            root_m[k] = root_m[k] ^ 8'h5A;
            pos_m[k]  = pos_m[k] + 3'd2;
        end
        for (int i = 0; i < NSYN; i++) hd_m[i] = 8'(i*53 + 100);
        drive_tables();
        issue(1, 1'b0);
        check_groups(g0, ngrp, "R5 R11 sampled-at-accept syndrome");
    endtask

    // R6: start while busy is ignored
    task automatic t_busy_start();
        int g0 = ngrp;
        issue(3, 1'b0);
        for (int n = 0; n < 6; n++) begin
            chk(ready_o == 1'b0, "R6 busy before stray start", int'(ready_o), 0);
            start_i = 1'b1;
            sel_i   = 2'd1;
            first_i = 1'b1;
            @(negedge clk);
        end
        start_i = 1'b0;
        first_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(ngot == ngrp*NSYN, "R6 no extra group", ngot, ngrp*NSYN);
        check_groups(g0, ngrp, "R6 busy-start syndrome");
    endtask

    // R9, R11: new sequence accepted in the final cycle of a running group
    task automatic t_reload_back_to_back();
        int g0 = ngrp;
        issue(0, 1'b0);
        for (int i = 0; i < NSYN; i++) hd_m[i] = 8'(i*19 + 200);
        drive_tables();
        issue(3, 1'b1);
        issue(2, 1'b0);
        check_groups(g0, ngrp, "R9 R11 reload syndrome");
    endtask

    initial begin
        root_m = '{8'h02, 8'h8E, 8'h53, 8'hE1};
        pos_m  = '{3'd0, 3'd7, 3'd3, 3'd5};
        for (int i = 0; i < NSYN; i++) begin
            hd_m[i] = 8'(i*29 + 7);
            cur[i]  = 8'h00;
        end
        drive_tables();
        repeat (4) @(negedge clk);
        chk(syn_valid_o == 1'b0, "R1 valid in reset", int'(syn_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_vector();
        t_continuation();
        t_hold_inputs();
        t_busy_start();
        t_reload_back_to_back();
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule